// File: doc/BRIEF.md
# Batched Memory Load-Store Sequencer

This block is the master control in front of a sparse matrix-vector compute engine. A start command latches an input base address and a result base address. The block then runs a loop of three phases. In the load phase it issues a fixed batch of tagged load requests to several memory controllers and collects the returned words into an input buffer. In the compute phase it starts the engine and waits for it to finish. In the store phase it writes a fixed batch of results back through the controllers. The loop then returns to the load phase with the same bases.

Each request goes to one controller only, chosen from the word-index bits of its address. Load tags come from a pool of reusable identifiers that are handed out and retired in order. Returned words are drained from one controller at a time in a fixed rotation, so the buffer fills in issue order even when controllers answer at different speeds. The engine reads the buffer through an index port and supplies its results through a second index port.

Top module: `batch_ldst_seq`

## Requirements
- R1: After a synchronous active-high reset, and until a start pulse, no request valid, no response pop, no engine start and no completion pulse is asserted, even when controllers present response data.
- R2: Load k of a batch uses address in_base + k*8 and store j uses address out_base + j*8 (8-byte words by default). Store j carries the engine result read at result index j.
- R3: A request goes to controller ((address / 8) mod 3). At most one controller request valid is high in any cycle, and the write flag is 1 for stores and 0 for loads.
- R4: A request that is not accepted keeps the same controller, address, tag and data until the selected controller asserts ready.
- R5: Load tags count up from 0 after reset, one per accepted load, wrapping from 255 to 0, and they continue across loop iterations.
- R6: Responses are popped only from the controller under a rotating pointer. The pointer starts at the controller of the first load address and steps 0, 1, 2, 0 after each pop. A valid response at any other controller is not popped, and a valid response at the pointer is popped in that cycle.
- R7: Exactly 21 loads are issued per batch. After the 21st pop, a one-cycle engine start and a one-cycle load-complete pulse appear together in the next cycle. Buffer entry k then holds the data of the k-th popped word.
- R8: Stores are issued only after the engine asserts done with has-result set. Exactly 11 stores are issued, and a one-cycle write-complete pulse appears in the cycle after the 11th store is accepted.
- R9: In the cycle of the write-complete pulse a new load request is already presented. If the engine asserts done with has-result clear, no store is issued and a new load request is presented in the next cycle.
- R10: The bases are latched only on a start pulse in the idle state. A start pulse or base change while the loop is running has no effect on the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the loop from idle |
| in_base | input | ADDR_W | Base address of the input words |
| out_base | input | ADDR_W | Base address of the results |
| mc_req_valid | output | NUM_MC | Per-controller request valid |
| mc_req_ready | input | NUM_MC | Per-controller request ready |
| mc_req_write | output | 1 | 1 = store, 0 = load |
| mc_req_addr | output | ADDR_W | Request byte address |
| mc_req_tag | output | TAG_W | Load tag |
| mc_req_wdata | output | DATA_W | Store data |
| mc_rsp_valid | input | NUM_MC | Per-controller response valid |
| mc_rsp_tag | input | NUM_MC*TAG_W | Per-controller response tag, controller 0 in low bits |
| mc_rsp_data | input | NUM_MC*DATA_W | Per-controller response data, controller 0 in low bits |
| mc_rsp_pop | output | NUM_MC | Response consumed this cycle |
| eng_start | output | 1 | One-cycle engine start |
| eng_done | input | 1 | Engine finished |
| eng_has_result | input | 1 | Results are to be written, qualifies eng_done |
| eng_rd_idx | input | LD_IDX_W | Engine read index into the input buffer |
| eng_rd_data | output | DATA_W | Input buffer word at eng_rd_idx |
| res_rd_idx | output | ST_IDX_W | Index of the result being stored |
| res_rd_data | input | DATA_W | Engine result at res_rd_idx |
| load_done | output | 1 | One-cycle load-complete pulse |
| write_done | output | 1 | One-cycle write-complete pulse |

## Verification
The bound checker checks, on every cycle, the single-hot request and pop vectors, the holding of a stalled request, the quiet idle state, the single-cycle completion pulses, the restriction of writes to the store phase, and the in-order return of tags. Only the bench scenarios show the address sequences and store data, the rotation start derived from the base address, the exact batch counts, the buffer contents, and the loop restart timing with and without results. The scenarios vary controller latency and ready patterns so that responses arrive out of rotation order, and one long run wraps the tag counter.

// File: rtl/bls_pkg.sv
package bls_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOAD  = 2'd1,
      PH_COMP  = 2'd2,
      PH_STORE = 2'd3
   } phase_e;
endpackage

// File: rtl/bls_mc_decode.sv
module bls_mc_decode #(
   parameter int ADDR_W     = 32,
   parameter int NUM_MC     = 3,
   parameter int WORD_BYTES = 8,
   parameter int SEL_W      = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SEL_W-1:0]  sel
);
   localparam int OFS_W = $clog2(WORD_BYTES);

   generate
      if (NUM_MC == 1) begin : g_single
         assign sel = '0;
      end else if ((NUM_MC & (NUM_MC - 1)) == 0) begin : g_pow2
         // power-of-two count: plain bit slice above the word offset
         assign sel = addr[OFS_W +: SEL_W];
      end else begin : g_mod
         logic [ADDR_W-1:0] word_idx;
         logic [ADDR_W-1:0] rem;
         assign word_idx = addr >> OFS_W;
         assign rem      = word_idx % ADDR_W'(NUM_MC);
         assign sel      = rem[SEL_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/bls_tag_pool.sv
module bls_tag_pool #(
   parameter int NUM_TAGS = 256,
   parameter int TAG_W    = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             alloc,
   input  logic             retire,
   output logic [TAG_W-1:0] alloc_tag,
   output logic             avail
);
   localparam int CNT_W = $clog2(NUM_TAGS + 1);
   localparam logic [TAG_W-1:0] TAG_LAST = TAG_W'(NUM_TAGS - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_TAGS);

   logic [TAG_W-1:0] head_q;
   logic [CNT_W-1:0] used_q;

   assign alloc_tag = head_q;
   assign avail     = (used_q != CNT_FULL);

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q <= '0;
         used_q <= '0;
      end else begin
         if (alloc) begin
            head_q <= (head_q == TAG_LAST) ? '0 : head_q + 1'b1;
         end
         case ({alloc, retire})
            2'b10:   used_q <= used_q + 1'b1;
            2'b01:   used_q <= used_q - 1'b1;
            default: used_q <= used_q;
         endcase
      end
   end
endmodule

// File: rtl/bls_drain.sv
module bls_drain #(
   parameter int NUM_MC = 3,
   parameter int SEL_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic                     enable,
   input  logic [SEL_W-1:0]         ptr,
   input  logic [NUM_MC-1:0]        rsp_valid,
   input  logic [NUM_MC*DATA_W-1:0] rsp_data,
   output logic [NUM_MC-1:0]        pop,
   output logic                     pop_any,
   output logic [DATA_W-1:0]        pop_data
);
   logic [DATA_W-1:0] lane_data [NUM_MC];

   generate
      for (genvar m = 0; m < NUM_MC; m++) begin : g_lane
         assign pop[m]       = enable && rsp_valid[m] && (ptr == SEL_W'(m));
         assign lane_data[m] = rsp_data[m*DATA_W +: DATA_W];
      end
   endgenerate

   assign pop_any  = |pop;
   assign pop_data = lane_data[ptr];
endmodule

// File: rtl/batch_ldst_seq.sv
module batch_ldst_seq
   import bls_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int NUM_MC      = 3,
   parameter int WORD_BYTES  = 8,
   parameter int NUM_TAGS    = 256,
   parameter int LOAD_WORDS  = 21,
   parameter int STORE_WORDS = 11,
   parameter int TAG_W       = $clog2(NUM_TAGS),
   parameter int SEL_W       = (NUM_MC > 1) ? $clog2(NUM_MC) : 1,
   parameter int LD_IDX_W    = $clog2(LOAD_WORDS + 1),
   parameter int ST_IDX_W    = $clog2(STORE_WORDS + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic [ADDR_W-1:0]        in_base,
   input  logic [ADDR_W-1:0]        out_base,
   output logic [NUM_MC-1:0]        mc_req_valid,
   input  logic [NUM_MC-1:0]        mc_req_ready,
   output logic                     mc_req_write,
   output logic [ADDR_W-1:0]        mc_req_addr,
   output logic [TAG_W-1:0]         mc_req_tag,
   output logic [DATA_W-1:0]        mc_req_wdata,
   input  logic [NUM_MC-1:0]        mc_rsp_valid,
   input  logic [NUM_MC*TAG_W-1:0]  mc_rsp_tag,
   input  logic [NUM_MC*DATA_W-1:0] mc_rsp_data,
   output logic [NUM_MC-1:0]        mc_rsp_pop,
   output logic                     eng_start,
   input  logic                     eng_done,
   input  logic                     eng_has_result,
   input  logic [LD_IDX_W-1:0]      eng_rd_idx,
   output logic [DATA_W-1:0]        eng_rd_data,
   output logic [ST_IDX_W-1:0]      res_rd_idx,
   input  logic [DATA_W-1:0]        res_rd_data,
   output logic                     load_done,
   output logic                     write_done
);
   localparam int OFS_W = $clog2(WORD_BYTES);
   localparam logic [LD_IDX_W-1:0] LD_TOTAL = LD_IDX_W'(LOAD_WORDS);
   localparam logic [LD_IDX_W-1:0] LD_LAST  = LD_IDX_W'(LOAD_WORDS - 1);
   localparam logic [ST_IDX_W-1:0] ST_LAST  = ST_IDX_W'(STORE_WORDS - 1);
   localparam logic [SEL_W-1:0]    PTR_LAST = SEL_W'(NUM_MC - 1);

   // elaboration-time parameter checks
   generate
      if (NUM_MC < 1) begin : g_bad_mc
         $error("NUM_MC must be at least 1");
      end
      if ((WORD_BYTES < 1) || ((WORD_BYTES & (WORD_BYTES - 1)) != 0)) begin : g_bad_wb
         $error("WORD_BYTES must be a power of two");
      end
      if ((LOAD_WORDS < 1) || (STORE_WORDS < 1)) begin : g_bad_batch
         $error("batch sizes must be at least 1");
      end
      if ((NUM_TAGS < 2) || ((1 << TAG_W) < NUM_TAGS)) begin : g_bad_tag
         $error("tag width too small for the tag pool");
      end
      if ((1 << SEL_W) < NUM_MC) begin : g_bad_sel
         $error("select width too small for controller count");
      end
   endgenerate

   phase_e phase_q;
   logic [ADDR_W-1:0]   in_base_q, out_base_q;
   logic [LD_IDX_W-1:0] iss_q, rcv_q;
   logic [ST_IDX_W-1:0] st_q;
   logic [SEL_W-1:0]    ptr_q;
   logic [DATA_W-1:0]   buf_q [LOAD_WORDS];
   logic                eng_start_q, load_done_q, write_done_q;

   // request address generation
   logic [ADDR_W-1:0] ld_addr, st_addr, req_addr, rot_base;
   logic [SEL_W-1:0]  req_sel, rot_sel;
   logic              tag_avail, req_any, req_fire, ld_fire, st_fire;
   logic [TAG_W-1:0]  tag_next;

   assign ld_addr  = in_base_q  + (ADDR_W'(iss_q) << OFS_W);
   assign st_addr  = out_base_q + (ADDR_W'(st_q)  << OFS_W);
   assign req_addr = (phase_q == PH_STORE) ? st_addr : ld_addr;
   assign rot_base = (phase_q == PH_IDLE) ? in_base : in_base_q;

   bls_mc_decode #(
      .ADDR_W(ADDR_W), .NUM_MC(NUM_MC), .WORD_BYTES(WORD_BYTES), .SEL_W(SEL_W)
   ) u_req_dec (
      .addr(req_addr), .sel(req_sel)
   );

   bls_mc_decode #(
      .ADDR_W(ADDR_W), .NUM_MC(NUM_MC), .WORD_BYTES(WORD_BYTES), .SEL_W(SEL_W)
   ) u_rot_dec (
      .addr(rot_base), .sel(rot_sel)
   );

   assign req_any = ((phase_q == PH_LOAD) && (iss_q < LD_TOTAL) && tag_avail) ||
                    (phase_q == PH_STORE);

   generate
      for (genvar m = 0; m < NUM_MC; m++) begin : g_req
         assign mc_req_valid[m] = req_any && (req_sel == SEL_W'(m));
      end
   endgenerate

   assign req_fire     = |(mc_req_valid & mc_req_ready);
   assign ld_fire      = req_fire && (phase_q == PH_LOAD);
   assign st_fire      = req_fire && (phase_q == PH_STORE);
   assign mc_req_write = (phase_q == PH_STORE);
   assign mc_req_addr  = req_addr;
   assign mc_req_tag   = tag_next;
   assign mc_req_wdata = res_rd_data;
   assign res_rd_idx   = st_q;

   // ordered response drain
   logic              drain_en, pop_any;
   logic [DATA_W-1:0] pop_data;

   assign drain_en = (phase_q == PH_LOAD) && (rcv_q < LD_TOTAL);

   bls_drain #(
      .NUM_MC(NUM_MC), .SEL_W(SEL_W), .DATA_W(DATA_W)
   ) u_drain (
      .enable(drain_en), .ptr(ptr_q), .rsp_valid(mc_rsp_valid),
      .rsp_data(mc_rsp_data), .pop(mc_rsp_pop), .pop_any(pop_any),
      .pop_data(pop_data)
   );

   // response tags are returned in issue order; the pool retires on every pop
   bls_tag_pool #(
      .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)
   ) u_tags (
      .clk(clk), .rst(rst), .alloc(ld_fire), .retire(pop_any),
      .alloc_tag(tag_next), .avail(tag_avail)
   );

   // phase sequencing
   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q      <= PH_IDLE;
         in_base_q    <= '0;
         out_base_q   <= '0;
         iss_q        <= '0;
         rcv_q        <= '0;
         st_q         <= '0;
         ptr_q        <= '0;
         eng_start_q  <= 1'b0;
         load_done_q  <= 1'b0;
         write_done_q <= 1'b0;
      end else begin
         eng_start_q  <= 1'b0;
         load_done_q  <= 1'b0;
         write_done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  in_base_q  <= in_base;
                  out_base_q <= out_base;
                  iss_q      <= '0;
                  rcv_q      <= '0;
                  ptr_q      <= rot_sel;
                  phase_q    <= PH_LOAD;
               end
            end
            PH_LOAD: begin
               if (ld_fire) begin
                  iss_q <= iss_q + 1'b1;
               end
               if (pop_any) begin
                  rcv_q <= rcv_q + 1'b1;
                  ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
                  if (rcv_q == LD_LAST) begin
                     eng_start_q <= 1'b1;
                     load_done_q <= 1'b1;
                     phase_q     <= PH_COMP;
                  end
               end
            end
            PH_COMP: begin
               if (eng_done) begin
                  if (eng_has_result) begin
                     st_q    <= '0;
                     phase_q <= PH_STORE;
                  end else begin
                     iss_q   <= '0;
                     rcv_q   <= '0;
                     ptr_q   <= rot_sel;
                     phase_q <= PH_LOAD;
                  end
               end
            end
            PH_STORE: begin
               if (st_fire) begin
                  st_q <= st_q + 1'b1;
                  if (st_q == ST_LAST) begin
                     write_done_q <= 1'b1;
                     iss_q        <= '0;
                     rcv_q        <= '0;
                     ptr_q        <= rot_sel;
                     phase_q      <= PH_LOAD;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   // input buffer, written in pop order
   always_ff @(posedge clk) begin
      if (pop_any && (rcv_q < LD_TOTAL)) begin
         buf_q[rcv_q] <= pop_data;
      end
   end

   assign eng_rd_data = (eng_rd_idx < LD_TOTAL) ? buf_q[eng_rd_idx] : '0;
   assign eng_start   = eng_start_q;
   assign load_done   = load_done_q;
   assign write_done  = write_done_q;
endmodule

// File: rtl/bls_seq_chk.sv
module bls_seq_chk #(
   parameter int NUM_MC = 3,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic [1:0]              phase,
   input logic [NUM_MC-1:0]       mc_req_valid,
   input logic [NUM_MC-1:0]       mc_req_ready,
   input logic                    mc_req_write,
   input logic [ADDR_W-1:0]       mc_req_addr,
   input logic [TAG_W-1:0]        mc_req_tag,
   input logic [DATA_W-1:0]       mc_req_wdata,
   input logic [NUM_MC-1:0]       mc_rsp_valid,
   input logic [NUM_MC*TAG_W-1:0] mc_rsp_tag,
   input logic [NUM_MC-1:0]       mc_rsp_pop,
   input logic                    load_done,
   input logic                    write_done
);
   logic [TAG_W-1:0] ret_tag_q;
   logic [TAG_W-1:0] popped_tag;

   always_comb begin
      popped_tag = '0;
      for (int m = 0; m < NUM_MC; m++) begin
         if (mc_rsp_pop[m]) popped_tag = popped_tag | mc_rsp_tag[m*TAG_W +: TAG_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) ret_tag_q <= '0;
      else if (|mc_rsp_pop) ret_tag_q <= ret_tag_q + 1'b1;
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd0) |-> ((mc_req_valid == '0) && (mc_rsp_pop == '0)));

   // R3
   req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mc_req_valid));

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((mc_req_valid != '0) && ((mc_req_valid & mc_req_ready) == '0)) |=>
      ((mc_req_valid == $past(mc_req_valid)) && $stable(mc_req_addr) &&
       $stable(mc_req_tag) && $stable(mc_req_write) && $stable(mc_req_wdata)));

   // R5
   tag_order_chk: assert property (@(posedge clk) disable iff (rst)
      (mc_rsp_pop != '0) |-> (popped_tag == ret_tag_q));

   // R6
   pop_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mc_rsp_pop) && ((mc_rsp_pop & ~mc_rsp_valid) == '0));

   // R7
   load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      load_done |=> !load_done);

   // R8
   write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      write_done |=> !write_done);

   // R8
   write_phase_chk: assert property (@(posedge clk) disable iff (rst)
      ((mc_req_valid != '0) && mc_req_write) |-> (phase == 2'd3));
endmodule

bind batch_ldst_seq bls_seq_chk #(
   .NUM_MC(NUM_MC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_chk (
   .clk(clk), .rst(rst), .phase(phase_q), .mc_req_valid(mc_req_valid),
   .mc_req_ready(mc_req_ready), .mc_req_write(mc_req_write),
   .mc_req_addr(mc_req_addr), .mc_req_tag(mc_req_tag),
   .mc_req_wdata(mc_req_wdata), .mc_rsp_valid(mc_rsp_valid),
   .mc_rsp_tag(mc_rsp_tag), .mc_rsp_pop(mc_rsp_pop),
   .load_done(load_done), .write_done(write_done)
);

// File: tb/sim_batch_ldst_seq.sv
`timescale 1ns/1ps
module sim_batch_ldst_seq;
   localparam int NMC = 3;
   localparam int AW  = 32;
   localparam int DW  = 32;
   localparam int TW  = 8;
   localparam int NLD = 21;
   localparam int NST = 11;
   localparam int LIW = 5;
   localparam int SIW = 4;
   localparam int WDOG = 150000;

   typedef struct packed {
      logic [31:0] ib;
      logic [31:0] ob;
      logic        res;
      logic [3:0]  pat;
      logic [3:0]  l0;
      logic [3:0]  l1;
      logic [3:0]  l2;
      logic [4:0]  it;
   } scn_t;

   // in_base, out_base, has-result, ready pattern, latencies MC0..MC2, iterations
   localparam scn_t SCN [5] = '{
      '{32'h0000_1000, 32'h0000_8000, 1'b1, 4'd0, 4'd1, 4'd1, 4'd1,  5'd2},
      '{32'h0000_1008, 32'h0000_9010, 1'b1, 4'd2, 4'd9, 4'd3, 4'd1,  5'd2},
      '{32'h0000_2000, 32'h0000_A000, 1'b0, 4'd1, 4'd2, 4'd5, 4'd3,  5'd3},
      '{32'h0000_1000, 32'h0000_8008, 1'b1, 4'd3, 4'd4, 4'd4, 4'd12, 5'd2},
      '{32'h0000_3018, 32'h0000_0000, 1'b0, 4'd0, 4'd1, 4'd2, 4'd3,  5'd13}
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic [AW-1:0]     in_base = '0, out_base = '0;
   logic [NMC-1:0]    mc_req_valid, mc_req_ready = '0;
   logic              mc_req_write;
   logic [AW-1:0]     mc_req_addr;
   logic [TW-1:0]     mc_req_tag;
   logic [DW-1:0]     mc_req_wdata;
   logic [NMC-1:0]    mc_rsp_valid = '0;
   logic [NMC*TW-1:0] mc_rsp_tag = '0;
   logic [NMC*DW-1:0] mc_rsp_data = '0;
   logic [NMC-1:0]    mc_rsp_pop;
   logic              eng_start, eng_done = 1'b0, eng_has_result = 1'b0;
   logic [LIW-1:0]    eng_rd_idx = '0;
   logic [DW-1:0]     eng_rd_data;
   logic [SIW-1:0]    res_rd_idx;
   logic [DW-1:0]     res_rd_data;
   logic              load_done, write_done;

   always #2.5 clk = ~clk;

   assign res_rd_data = 32'hBEEF_0000 | 32'(res_rd_idx);

   batch_ldst_seq u0 (
      .clk(clk), .rst(rst), .start(start), .in_base(in_base), .out_base(out_base),
      .mc_req_valid(mc_req_valid), .mc_req_ready(mc_req_ready),
      .mc_req_write(mc_req_write), .mc_req_addr(mc_req_addr),
      .mc_req_tag(mc_req_tag), .mc_req_wdata(mc_req_wdata),
      .mc_rsp_valid(mc_rsp_valid), .mc_rsp_tag(mc_rsp_tag),
      .mc_rsp_data(mc_rsp_data), .mc_rsp_pop(mc_rsp_pop),
      .eng_start(eng_start), .eng_done(eng_done), .eng_has_result(eng_has_result),
      .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data),
      .res_rd_idx(res_rd_idx), .res_rd_data(res_rd_data),
      .load_done(load_done), .write_done(write_done)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // bench model state
   logic [31:0] cur_in = '0, cur_out = '0;
   bit          cur_res = 1'b0;
   int          pat = 0;
   int          lat [NMC];
   int          b_phase = 0;   // 0 idle, 1 load, 2 compute, 3 store
   int          ld_n = 0, pop_n = 0, st_n = 0, exp_ptr = 0, eng_k = 0;
   logic [7:0]  exp_tag = '0;
   int          iters_done = 0;
   bit          want_req = 1'b0;
   bit          force_rsp = 1'b0;
   logic [NMC-1:0] prev_vec = '0;
   logic [AW-1:0]  prev_addr = '0;
   bit          prev_hs = 1'b0;

   logic [TW-1:0] rq_tag  [NMC][64];
   logic [DW-1:0] rq_data [NMC][64];
   int            rq_due  [NMC][64];
   int            rq_wr   [NMC];
   int            rq_rd   [NMC];

   function automatic logic [31:0] ld_word(input logic [31:0] a);
      return (a * 32'd3) ^ 32'h5A5A_0000;
   endfunction

   function automatic int mc_of(input logic [31:0] a);
      return int'((a >> 3) % 32'd3);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic restart_load();
      ld_n    = 0;
      pop_n   = 0;
      st_n    = 0;
      exp_ptr = mc_of(cur_in);
      b_phase = 1;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc >= WDOG) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
      // drive controller and engine inputs for this cycle
      eng_done = 1'b0;
      for (int m = 0; m < NMC; m++) begin
         mc_req_ready[m] = (pat == 0) ? 1'b1 : (((cyc + m) % (pat + 1)) != 0);
         if (force_rsp) begin
            mc_rsp_valid[m] = 1'b1;
            mc_rsp_tag[m*TW +: TW]  = 8'h77;
            mc_rsp_data[m*DW +: DW] = 32'h1234_5678;
         end else if ((rq_rd[m] != rq_wr[m]) && (rq_due[m][rq_rd[m] % 64] <= cyc)) begin
            mc_rsp_valid[m] = 1'b1;
            mc_rsp_tag[m*TW +: TW]  = rq_tag[m][rq_rd[m] % 64];
            mc_rsp_data[m*DW +: DW] = rq_data[m][rq_rd[m] % 64];
         end else begin
            mc_rsp_valid[m] = 1'b0;
         end
      end
      if (b_phase == 2) begin
         if (eng_k < NLD) eng_rd_idx = LIW'(eng_k);
         else if (eng_k == NLD) begin
            eng_done       = 1'b1;
            eng_has_result = cur_res;
         end
      end
      #1;
      if (!rst) begin
         if (want_req) begin
            // R9: loop restarts at once when there is nothing to write
            chk("R9", "load request after done without result",
                32'((mc_req_valid != '0) && !mc_req_write), 32'd1);
            want_req = 1'b0;
         end
         if (write_done) begin
            chk("R8", "store count at write-complete", 32'(st_n), 32'(NST));
            chk("R9", "load request in write-complete cycle",
                32'((mc_req_valid != '0) && !mc_req_write), 32'd1);
            iters_done++;
            restart_load();
         end
         if (eng_start) begin
            chk("R7", "loads issued at engine start", 32'(ld_n), 32'(NLD));
            chk("R7", "words popped at engine start", 32'(pop_n), 32'(NLD));
            chk("R7", "load-complete with engine start", 32'(load_done), 32'd1);
            b_phase = 2;
            eng_k   = 0;
         end else if (load_done) begin
            chk("R7", "load-complete without engine start", 32'd0, 32'd1);
         end
         if (b_phase == 2 && eng_k < NLD && !eng_start) begin
            chk("R7", $sformatf("buffer word %0d", eng_k), eng_rd_data,
                ld_word(cur_in + 32'(eng_k) * 32'd8));
            eng_k++;
         end
         // request observation
         chk("R3", "request valid single-hot", 32'($countones(mc_req_valid) <= 1), 32'd1);
         if (prev_vec != '0 && !prev_hs) begin
            chk("R4", "stalled request held",
                32'((mc_req_valid == prev_vec) && (mc_req_addr == prev_addr)), 32'd1);
         end
         prev_hs = 1'b0;
         if ((mc_req_valid & mc_req_ready) != '0) begin
            int sel;
            sel = 0;
            for (int m = 0; m < NMC; m++) if (mc_req_valid[m]) sel = m;
            prev_hs = 1'b1;
            chk("R3", "controller select", 32'(sel), 32'(mc_of(mc_req_addr)));
            if (mc_req_write) begin
               chk("R8", "store only in store phase", 32'(b_phase), 32'd3);
               chk("R2", "store address", mc_req_addr, cur_out + 32'(st_n) * 32'd8);
               chk("R2", "store data", mc_req_wdata, 32'hBEEF_0000 | 32'(st_n));
               st_n++;
            end else begin
               chk("R7", "load only in load phase", 32'(b_phase), 32'd1);
               chk("R2/R10", "load address", mc_req_addr, cur_in + 32'(ld_n) * 32'd8);
               chk("R5", "load tag", 32'(mc_req_tag), 32'(exp_tag));
               chk("R7", "load count within batch", 32'(ld_n < NLD), 32'd1);
               rq_tag [sel][rq_wr[sel] % 64] = mc_req_tag;
               rq_data[sel][rq_wr[sel] % 64] = ld_word(mc_req_addr);
               rq_due [sel][rq_wr[sel] % 64] = cyc + lat[sel];
               rq_wr[sel]++;
               exp_tag++;
               ld_n++;
            end
         end
         prev_vec  = mc_req_valid;
         prev_addr = mc_req_addr;
         // response drain observation
         if (mc_rsp_pop != '0) begin
            chk("R6", "pop at rotation pointer", 32'(mc_rsp_pop), 32'(1 << exp_ptr));
            for (int m = 0; m < NMC; m++) if (mc_rsp_pop[m]) rq_rd[m]++;
            exp_ptr = (exp_ptr + 1) % NMC;
            pop_n++;
         end else if (b_phase == 1 && pop_n < NLD && mc_rsp_valid[exp_ptr]) begin
            chk("R6", "valid word at pointer not popped", 32'd0, 32'd1);
         end
         if (eng_done) begin
            if (cur_res) begin
               b_phase = 3;
               st_n    = 0;
            end else begin
               iters_done++;
               restart_load();
               want_req = 1'b1;
            end
            eng_k++;
         end
      end
   end

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst = 1'b1;
      start = 1'b0;
      b_phase = 0;
      exp_tag = '0;
      iters_done = 0;
      want_req = 1'b0;
      prev_vec = '0;
      prev_hs = 1'b0;
      ld_n = 0; pop_n = 0; st_n = 0; eng_k = 0;
      for (int m = 0; m < NMC; m++) begin
         rq_wr[m] = 0;
         rq_rd[m] = 0;
      end
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b0;
   endtask

   task automatic launch(input logic [31:0] ib, input logic [31:0] ob);
      @(posedge clk);
      #1;
      cur_in   = ib;
      cur_out  = ob;
      in_base  = ib;
      out_base = ob;
      start    = 1'b1;
      restart_load();
      @(posedge clk);
      #1;
      start = 1'b0;
   endtask

   initial begin
      for (int m = 0; m < NMC; m++) begin
         lat[m] = 1;
         rq_wr[m] = 0;
         rq_rd[m] = 0;
      end

      // table-driven scenarios
      for (int s = 0; s < 5; s++) begin
         int waited;
         pat     = int'(SCN[s].pat);
         lat[0]  = int'(SCN[s].l0);
         lat[1]  = int'(SCN[s].l1);
         lat[2]  = int'(SCN[s].l2);
         cur_res = SCN[s].res;
         do_reset();
         launch(SCN[s].ib, SCN[s].ob);
         // R10: changed bases and a second start while running are ignored
         in_base  = 32'hDEAD_0000;
         out_base = 32'hDEAD_8000;
         repeat (3) @(posedge clk);
         #1 start = 1'b1;
         @(posedge clk);
         #1 start = 1'b0;
         waited = 0;
         while (iters_done < int'(SCN[s].it) && waited < 6000) begin
            @(posedge clk);
            waited++;
         end
         chk("R9", $sformatf("scenario %0d iterations completed", s),
             32'(iters_done >= int'(SCN[s].it)), 32'd1);
      end

      // R1: quiet after reset, response valids ignored, no start
      pat = 0;
      do_reset();
      force_rsp = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         #2;
         chk("R1", "no request after reset", 32'(mc_req_valid), 32'd0);
         chk("R1", "no pop after reset", 32'(mc_rsp_pop), 32'd0);
         chk("R1", "no pulses after reset",
             32'({eng_start, load_done, write_done}), 32'd0);
      end
      force_rsp = 1'b0;

      // R10: directed re-start during the loop keeps the latched base
      cur_res = 1'b1;
      launch(32'h0000_4000, 32'h0000_C000);
      #0.5;
      chk("R10", "first load address after start", mc_req_addr, 32'h0000_4000);
      in_base = 32'h0000_7770;
      start   = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      begin
         int waited;
         waited = 0;
         while (iters_done < 1 && waited < 3000) begin
            @(posedge clk);
            waited++;
         end
      end
      @(negedge clk);
      #2;
      chk("R10", "loop keeps latched base", mc_req_addr & 32'hFFFF_FF00, 32'h0000_4000);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule